// File: doc/BRIEF.md
# Fetch Stall and Squash Status Sequencer

This block decides, every cycle, what fetch status each hardware thread should move to. It tracks why a thread is being held back and applies a fixed priority among redirect and back-pressure requests. Each of the four stages behind fetch (decode, rename, execute, commit) can send a thread a block pulse and, later, an unblock pulse. The block keeps one sticky stall flag per stage per thread from these pulses. Squash requests from commit and from decode, a reorder-buffer-still-squashing indication from commit, and a global context-switch hold are combined with those flags and with the thread's present status to give its next status and a flag that says whether the status changed.

The present status is held by the surrounding fetch engine, which also moves threads into and out of the cache-wait states. This block only sequences the stall and squash transitions. It also watches the whole stage: the stage counts as busy while any thread is headed for Running, Squashing or AccessDone. A one-cycle pulse marks each change from idle to busy and from busy to idle.

Top module: `fetch_stall_tracker`

## Requirements
- R1: While `rst` is high, every thread reports Running (code 0) with `statusChanged` low. After reset, all stall flags are clear, the stage is counted busy, and neither activity pulse is high.
- R2: A block pulse on bit t*4+s of `stageBlock` sets stage s's stall flag for thread t (stage 0 decode, 1 rename, 2 execute, 3 commit). The flag stays set on later cycles until it is cleared.
- R3: An unblock pulse on the same bit of `stageUnblock` clears the flag. It takes effect in the same cycle it arrives. When block and unblock arrive together, block wins and the flag stays set.
- R4: `protoErr[t]` is high in any cycle where thread t receives an unblock for a stage whose flag is clear, or an unblock together with a block for the same stage.
- R5: A commit squash gives Squashing (code 2) with a change reported. This holds whatever the present status, stall state or other requests.
- R6: With no commit squash, the reorder-buffer-squashing flag gives Squashing with a change reported.
- R7: With neither commit input, a decode squash gives Squashing with a change reported, unless the present status is already Squashing. In that case the decode squash has no effect, and the lower-priority rules decide.
- R8: A thread is stalled when `ctxSwitch` is high or any of its four flags (after this cycle's pulses) is set. A stalled thread goes to Blocked (code 3) with a change reported. The exception is a thread in WaitResponse (code 5), which holds with no change.
- R9: With no squash and no stall, a thread in Blocked or Squashing goes to Running with a change reported.
- R10: In all other cases the present status is held and `statusChanged` is low. The other codes are Idle 1, WaitRetry 4 and AccessDone 6.
- R11: The stage is busy when any thread's next status is Running, Squashing or AccessDone. On the clock edge after a cycle that goes from idle to busy, `stageActivate` pulses for one cycle. `stageDeactivate` pulses the same way for busy to idle.
- R12: Each thread is sequenced independently. Requests addressed to one thread leave every other thread's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stageBlock | input | NUM_THREADS*4 | Block pulses, bit t*4+s for thread t, stage s |
| stageUnblock | input | NUM_THREADS*4 | Unblock pulses, same layout |
| commitSquash | input | NUM_THREADS | Squash request from commit, per thread |
| robSquashing | input | NUM_THREADS | Reorder buffer still squashing, per thread |
| decodeSquash | input | NUM_THREADS | Squash request from decode, per thread |
| ctxSwitch | input | 1 | Global hold for a context switch |
| curStatus | input | NUM_THREADS*3 | Present status per thread, bits t*3+:3 |
| nextStatus | output | NUM_THREADS*3 | Next status per thread, bits t*3+:3 |
| statusChanged | output | NUM_THREADS | Status transition reported, per thread |
| protoErr | output | NUM_THREADS | Unblock protocol violation, per thread |
| stageActivate | output | 1 | Pulse: stage went from idle to busy |
| stageDeactivate | output | 1 | Pulse: stage went from busy to idle |

## Verification
The assertions assume that `curStatus` carries only the seven defined codes. They also assume the stimulus changes only between clock edges. The bench drives on the falling edge and samples combinational results shortly after, then samples registered pulses just after the rising edge. The only deliberate unblock protocol violations appear in the R3 and R4 scenarios. No assertion forbids them, because flagging them is the block's own job. Every other sequence pairs each block with one later unblock and ends with all flags clear.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STAT_W     = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_RUNNING     = 3'd0,
    ST_IDLE        = 3'd1,
    ST_SQUASHING   = 3'd2,
    ST_BLOCKED     = 3'd3,
    ST_WAIT_RETRY  = 3'd4,
    ST_WAIT_RESP   = 3'd5,
    ST_ACCESS_DONE = 3'd6
  } fetch_status_e;

  // Per-thread strobes from control to the flag datapath
  typedef struct packed {
    logic [NUM_STAGES-1:0] setMask;
    logic [NUM_STAGES-1:0] clrMask;
  } flag_strobe_t;
endpackage

// File: rtl/fst_stall_flags.sv
module fst_stall_flags
  import fst_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  flag_strobe_t           strobes [NUM_THREADS],
  output logic [NUM_THREADS-1:0] stallAny,
  output logic [NUM_THREADS-1:0] flagSet
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [NUM_STAGES-1:0] flagQ;
    logic [NUM_STAGES-1:0] flagNext;

    // set wins over clear
    assign flagNext    = (flagQ & ~strobes[t].clrMask) | strobes[t].setMask;
    assign stallAny[t] = |flagNext;
    assign flagSet[t]  = |flagQ;

    always_ff @(posedge clk) begin
      if (rst) flagQ <= '0;
      else     flagQ <= flagNext;
    end
  end
endmodule

// File: rtl/fst_status_ctrl.sv
module fst_status_ctrl
  import fst_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int FLAG_W = NUM_THREADS * NUM_STAGES,
  localparam int STS_W  = NUM_THREADS * STAT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FLAG_W-1:0]      stageBlock,
  input  logic [FLAG_W-1:0]      stageUnblock,
  input  logic [NUM_THREADS-1:0] commitSquash,
  input  logic [NUM_THREADS-1:0] robSquashing,
  input  logic [NUM_THREADS-1:0] decodeSquash,
  input  logic                   ctxSwitch,
  input  logic [STS_W-1:0]       curStatus,
  input  logic [NUM_THREADS-1:0] stallAny,
  input  logic [NUM_THREADS-1:0] flagSet,
  output flag_strobe_t           strobes [NUM_THREADS],
  output logic [STS_W-1:0]       nextStatus,
  output logic [NUM_THREADS-1:0] statusChanged,
  output logic [NUM_THREADS-1:0] protoErr,
  output logic                   stageActivate,
  output logic                   stageDeactivate
);
  logic activeQ;
  logic busyNext;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_strb
    logic [NUM_STAGES-1:0] blk;
    logic [NUM_STAGES-1:0] ublk;
    assign blk  = stageBlock[t*NUM_STAGES +: NUM_STAGES];
    assign ublk = stageUnblock[t*NUM_STAGES +: NUM_STAGES];
    assign strobes[t].setMask = blk;
    assign strobes[t].clrMask = ublk & ~blk;
  end

  // protocol check needs per-stage flag view: rebuilt from strobes history
  logic [NUM_STAGES-1:0] shadowQ [NUM_THREADS];
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_err
    logic [NUM_STAGES-1:0] ublk;
    assign ublk        = stageUnblock[t*NUM_STAGES +: NUM_STAGES];
    assign protoErr[t] = |(ublk & (~shadowQ[t] | strobes[t].setMask));
    always_ff @(posedge clk) begin
      if (rst) shadowQ[t] <= '0;
      else     shadowQ[t] <= (shadowQ[t] & ~strobes[t].clrMask) | strobes[t].setMask;
    end
  end

  always_comb begin
    fetch_status_e cur;
    fetch_status_e nxt;
    logic          chg;
    busyNext = 1'b0;
    nextStatus    = '0;
    statusChanged = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      cur = fetch_status_e'(curStatus[t*STAT_W +: STAT_W]);
      nxt = cur;
      chg = 1'b0;
      if (rst) begin
        nxt = ST_RUNNING;
      end else if (commitSquash[t] || robSquashing[t]) begin
        nxt = ST_SQUASHING;
        chg = 1'b1;
      end else if (decodeSquash[t] && cur != ST_SQUASHING) begin
        nxt = ST_SQUASHING;
        chg = 1'b1;
      end else if ((ctxSwitch || stallAny[t]) && cur != ST_WAIT_RESP) begin
        nxt = ST_BLOCKED;
        chg = 1'b1;
      end else if (cur == ST_BLOCKED || cur == ST_SQUASHING) begin
        nxt = ST_RUNNING;
        chg = 1'b1;
      end
      nextStatus[t*STAT_W +: STAT_W] = nxt;
      statusChanged[t] = chg;
      if (nxt == ST_RUNNING || nxt == ST_SQUASHING || nxt == ST_ACCESS_DONE)
        busyNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ         <= 1'b1;
      stageActivate   <= 1'b0;
      stageDeactivate <= 1'b0;
    end else begin
      activeQ         <= busyNext;
      stageActivate   <= busyNext & ~activeQ;
      stageDeactivate <= ~busyNext & activeQ;
    end
  end

  logic unusedFlagSet;
  assign unusedFlagSet = ^flagSet;
endmodule

// File: rtl/fetch_stall_tracker.sv
module fetch_stall_tracker
  import fst_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int FLAG_W = NUM_THREADS * NUM_STAGES,
  localparam int STS_W  = NUM_THREADS * STAT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FLAG_W-1:0]      stageBlock,
  input  logic [FLAG_W-1:0]      stageUnblock,
  input  logic [NUM_THREADS-1:0] commitSquash,
  input  logic [NUM_THREADS-1:0] robSquashing,
  input  logic [NUM_THREADS-1:0] decodeSquash,
  input  logic                   ctxSwitch,
  input  logic [STS_W-1:0]       curStatus,
  output logic [STS_W-1:0]       nextStatus,
  output logic [NUM_THREADS-1:0] statusChanged,
  output logic [NUM_THREADS-1:0] protoErr,
  output logic                   stageActivate,
  output logic                   stageDeactivate
);
  flag_strobe_t           strobes [NUM_THREADS];
  logic [NUM_THREADS-1:0] stallAny;
  logic [NUM_THREADS-1:0] flagSet;

  fst_stall_flags #(.NUM_THREADS(NUM_THREADS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .stallAny (stallAny),
    .flagSet  (flagSet)
  );

  fst_status_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .stageBlock      (stageBlock),
    .stageUnblock    (stageUnblock),
    .commitSquash    (commitSquash),
    .robSquashing    (robSquashing),
    .decodeSquash    (decodeSquash),
    .ctxSwitch       (ctxSwitch),
    .curStatus       (curStatus),
    .stallAny        (stallAny),
    .flagSet         (flagSet),
    .strobes         (strobes),
    .nextStatus      (nextStatus),
    .statusChanged   (statusChanged),
    .protoErr        (protoErr),
    .stageActivate   (stageActivate),
    .stageDeactivate (stageDeactivate)
  );
endmodule

// File: rtl/fst_checker.sv
module fst_checker
  import fst_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int FLAG_W = NUM_THREADS * NUM_STAGES,
  localparam int STS_W  = NUM_THREADS * STAT_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic [FLAG_W-1:0]      stageBlock,
  input logic [FLAG_W-1:0]      stageUnblock,
  input logic [NUM_THREADS-1:0] commitSquash,
  input logic [NUM_THREADS-1:0] robSquashing,
  input logic [NUM_THREADS-1:0] decodeSquash,
  input logic                   ctxSwitch,
  input logic [STS_W-1:0]       curStatus,
  input logic [STS_W-1:0]       nextStatus,
  input logic [NUM_THREADS-1:0] statusChanged,
  input logic [NUM_THREADS-1:0] protoErr,
  input logic                   stageActivate,
  input logic                   stageDeactivate
);
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(stageActivate && stageDeactivate)); // R11
  AST_ACTIVATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stageActivate |=> !stageActivate); // R11
  AST_DEACTIVATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stageDeactivate |=> !stageDeactivate); // R11

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [STAT_W-1:0] cur;
    logic [STAT_W-1:0] nxt;
    logic [NUM_STAGES-1:0] blk;
    logic [NUM_STAGES-1:0] ublk;
    assign cur  = curStatus[t*STAT_W +: STAT_W];
    assign nxt  = nextStatus[t*STAT_W +: STAT_W];
    assign blk  = stageBlock[t*NUM_STAGES +: NUM_STAGES];
    assign ublk = stageUnblock[t*NUM_STAGES +: NUM_STAGES];

    AST_COMMIT_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
      commitSquash[t] |-> (nxt == ST_SQUASHING && statusChanged[t])); // R5
    AST_WAIT_RESP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_WAIT_RESP && !commitSquash[t] && !robSquashing[t] && !decodeSquash[t])
        |-> (nxt == ST_WAIT_RESP && !statusChanged[t])); // R8
    AST_NO_CHANGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !statusChanged[t] |-> nxt == cur); // R10
    AST_BOTH_PULSES_ERR: assert property (@(posedge clk) disable iff (rst)
      (|(blk & ublk)) |-> protoErr[t]); // R4
    AST_CTX_STALLS: assert property (@(posedge clk) disable iff (rst)
      (ctxSwitch && !commitSquash[t] && !robSquashing[t] && !decodeSquash[t]
        && cur != ST_WAIT_RESP) |-> nxt == ST_BLOCKED); // R8
  end
endmodule

bind fetch_stall_tracker fst_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (.*);

// File: tb/fetch_stall_tracker_tb.sv
module fetch_stall_tracker_tb;
  localparam int NT = 4;
  localparam int NS = 4;

  localparam logic [2:0] RUN = 3'd0, IDL = 3'd1, SQ = 3'd2, BLK = 3'd3,
                         WRT = 3'd4, WRS = 3'd5, ADN = 3'd6;

  logic clk = 1'b0;
  logic rst;
  logic [NT*NS-1:0] stageBlock, stageUnblock;
  logic [NT-1:0]    commitSquash, robSquashing, decodeSquash;
  logic             ctxSwitch;
  logic [NT*3-1:0]  curStatus, nextStatus;
  logic [NT-1:0]    statusChanged, protoErr;
  logic             stageActivate, stageDeactivate;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  fetch_stall_tracker #(.NUM_THREADS(NT)) u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkThr(input string tag, input int t, input logic [2:0] st, input logic chg);
    check({tag, " status"}, int'(nextStatus[t*3 +: 3]), int'(st));
    check({tag, " changed"}, int'(statusChanged[t]), int'(chg));
  endtask

  task automatic idleIns();
    stageBlock = '0; stageUnblock = '0; commitSquash = '0;
    robSquashing = '0; decodeSquash = '0; ctxSwitch = 1'b0;
    for (int t = 0; t < NT; t++) curStatus[t*3 +: 3] = RUN;
  endtask

  task automatic setCur(input int t, input logic [2:0] st);
    curStatus[t*3 +: 3] = st;
  endtask

  // drive at falling edge, settle, then caller checks
  task automatic stepDrive();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; idleIns();
    setCur(1, BLK);
    repeat (3) @(negedge clk);
    #1;
    chkThr("R1 reset thr1", 1, RUN, 1'b0);
    rst = 1'b0; idleIns();
    @(posedge clk); #1;
    check("R1 no activate", int'(stageActivate), 0);
    check("R1 no deactivate", int'(stageDeactivate), 0);
    @(negedge clk); #1;
    for (int t = 0; t < NT; t++) chkThr("R1 flags clear", t, RUN, 1'b0);
  endtask

  task automatic t_block_sticky();
    idleIns(); stageBlock[1*NS+1] = 1'b1; #1;
    chkThr("R2 block now", 1, BLK, 1'b1);
    stepDrive(); idleIns(); setCur(1, BLK); #1;
    chkThr("R2 sticky", 1, BLK, 1'b1);
    stepDrive(); idleIns(); setCur(1, RUN); #1;
    chkThr("R2 sticky from running", 1, BLK, 1'b1);
    stepDrive(); idleIns(); setCur(1, BLK); stageUnblock[1*NS+1] = 1'b1; #1;
    chkThr("R3 unblock releases", 1, RUN, 1'b1);
    check("R3 legal unblock no err", int'(protoErr[1]), 0);
    stepDrive(); idleIns(); #1;
    chkThr("R3 stays clear", 1, RUN, 1'b0);
    stepDrive();
  endtask

  task automatic t_block_wins();
    idleIns(); stageBlock[2*NS+0] = 1'b1;
    stepDrive(); idleIns(); setCur(2, BLK);
    stageBlock[2*NS+0] = 1'b1; stageUnblock[2*NS+0] = 1'b1; #1;
    chkThr("R3 block wins", 2, BLK, 1'b1);
    check("R4 both pulses err", int'(protoErr[2]), 1);
    stepDrive(); idleIns(); setCur(2, BLK); #1;
    chkThr("R3 flag kept", 2, BLK, 1'b1);
    stageUnblock[2*NS+0] = 1'b1; #1;
    chkThr("R3 later unblock", 2, RUN, 1'b1);
    check("R4 legal unblock", int'(protoErr[2]), 0);
    stepDrive();
  endtask

  task automatic t_proto_err();
    idleIns(); stageUnblock[3*NS+2] = 1'b1; #1;
    check("R4 unblock on clear flag", int'(protoErr[3]), 1);
    chkThr("R4 status unaffected", 3, RUN, 1'b0);
    check("R12 other thread no err", int'(protoErr[0]), 0);
    stepDrive(); idleIns(); #1;
    check("R4 err gone", int'(protoErr[3]), 0);
    stepDrive();
  endtask

  task automatic t_commit_prio();
    idleIns(); setCur(0, WRS); ctxSwitch = 1'b1;
    commitSquash[0] = 1'b1; decodeSquash[0] = 1'b1; robSquashing[0] = 1'b1; #1;
    chkThr("R5 commit over all", 0, SQ, 1'b1);
    setCur(0, SQ); robSquashing[0] = 1'b0; decodeSquash[0] = 1'b0; #1;
    chkThr("R5 commit while squashing", 0, SQ, 1'b1);
    ctxSwitch = 1'b0; commitSquash[0] = 1'b0; #1;
    chkThr("R5 release after", 0, RUN, 1'b1);
    stepDrive();
  endtask

  task automatic t_rob();
    idleIns(); setCur(1, SQ); robSquashing[1] = 1'b1; ctxSwitch = 1'b1; #1;
    chkThr("R6 rob squashing holds", 1, SQ, 1'b1);
    setCur(1, IDL); #1;
    chkThr("R6 rob from idle", 1, SQ, 1'b1);
    stepDrive();
  endtask

  task automatic t_decode();
    idleIns(); decodeSquash[2] = 1'b1; #1;
    chkThr("R7 decode squash", 2, SQ, 1'b1);
    setCur(2, SQ); #1;
    chkThr("R7 ignored while squashing", 2, RUN, 1'b1);
    ctxSwitch = 1'b1; #1;
    chkThr("R7 falls to stall", 2, BLK, 1'b1);
    stepDrive();
  endtask

  task automatic t_stall();
    idleIns(); ctxSwitch = 1'b1; setCur(3, WRS); #1;
    for (int t = 0; t < 3; t++) chkThr("R8 ctx stalls", t, BLK, 1'b1);
    chkThr("R8 wait response held", 3, WRS, 1'b0);
    ctxSwitch = 1'b0; stageBlock[3*NS+3] = 1'b1; #1;
    chkThr("R8 flag with wait response", 3, WRS, 1'b0);
    stepDrive(); idleIns(); setCur(3, IDL); #1;
    chkThr("R8 stalled idle", 3, BLK, 1'b1);
    stageUnblock[3*NS+3] = 1'b1; #1;
    chkThr("R10 idle after unblock", 3, IDL, 1'b0);
    stepDrive();
  endtask

  task automatic t_release_hold();
    idleIns(); setCur(0, BLK); setCur(1, SQ); setCur(2, WRT); setCur(3, ADN); #1;
    chkThr("R9 blocked release", 0, RUN, 1'b1);
    chkThr("R9 squashing release", 1, RUN, 1'b1);
    chkThr("R10 wait retry held", 2, WRT, 1'b0);
    chkThr("R10 access done held", 3, ADN, 1'b0);
    stepDrive();
  endtask

  task automatic t_activity();
    idleIns();
    for (int t = 0; t < NT; t++) setCur(t, WRS);
    @(posedge clk); #1;
    check("R11 deactivate pulse", int'(stageDeactivate), 1);
    check("R11 no activate", int'(stageActivate), 0);
    @(posedge clk); #1;
    check("R11 deactivate single", int'(stageDeactivate), 0);
    @(negedge clk); setCur(2, ADN);
    @(posedge clk); #1;
    check("R11 activate pulse", int'(stageActivate), 1);
    @(posedge clk); #1;
    check("R11 activate single", int'(stageActivate), 0);
    @(negedge clk);
  endtask

  task automatic t_indep();
    idleIns(); commitSquash[0] = 1'b1; stageBlock[1*NS+2] = 1'b1; setCur(3, BLK); #1;
    chkThr("R12 thr0 squash", 0, SQ, 1'b1);
    chkThr("R12 thr1 blocked", 1, BLK, 1'b1);
    chkThr("R12 thr2 untouched", 2, RUN, 1'b0);
    chkThr("R12 thr3 released", 3, RUN, 1'b1);
    stepDrive(); idleIns(); stageUnblock[1*NS+2] = 1'b1; #1;
    chkThr("R12 thr1 cleared", 1, RUN, 1'b0);
    stepDrive();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; idleIns();
    @(negedge clk);
    t_reset();
    t_block_sticky();
    t_block_wins();
    t_proto_err();
    t_commit_prio();
    t_rob();
    t_decode();
    t_stall();
    t_release_hold();
    t_activity();
    t_indep();
    summary();
  end
endmodule